// File: doc/BRIEF.md
# Clock Source Switch Sequencer

This block steps one clock domain from its present clock source to a new one through a two-level selection. The primary select picks one of three inputs: the secondary mux output, the main PLL, or the main PLL divided by two. The secondary select picks one of three inputs: a bus clock, a second PLL, or an auxiliary clock that is always running. The block drives only the select codes and the control requests. The muxes and the PLL analog circuits sit outside it.

A request carries a target primary code, a target secondary code and a PLL multiplier. The target is taken to be the main PLL when its primary code is non-zero. The block compares the target with the source it is currently on and picks one of four step lists. When the PLL has to be retuned, the domain first moves to the auxiliary clock. Each PLL disable or enable is passed to an attached PLL sequencer as a one-cycle start with a command level, and the block waits for that sequencer's done before going on. Each select write is followed by a settle wait of a set number of cycles. A one-cycle done pulse ends each request.

Top module: `css_switch_seq`

## Requirements
- R1: After reset the control word is 0x08 (secondary = auxiliary, primary = secondary mux, divider field 0). req_ready is 1. done, pll_start, pll_en, pll_vreg and cur_is_pll are 0, and pll_mult is 0.
- R2: Control word layout: bits [1:0] hold the primary code (0 secondary mux, 1 PLL, 2 PLL/2). Bits [3:2] hold the secondary code (0 bus clock, 1 second PLL, 2 auxiliary). Bits [7:6], the divider ratio field, are held at 0, and bits [5:4] are always 0.
- R3: From a non-PLL source to a non-PLL target, only the secondary field is written, with the target code. There is no PLL start and no multiplier load.
- R4: From a non-PLL source to a PLL target, the steps run in this order: load the multiplier, enable the PLL with pll_vreg raised, then write the target primary code. The secondary field is left as it was.
- R5: From the PLL to a non-PLL target, the steps run in this order: write the target secondary, write the target primary, then disable the PLL and drop pll_vreg. The multiplier is not loaded.
- R6: From the PLL to a PLL target, the steps run in this order: secondary to auxiliary, primary to 0, disable, load the multiplier, enable, then primary to target. pll_vreg stays 1 throughout. A non-zero primary code never appears while pll_en is 0.
- R7: Two successive changes of the control word are at least SETTLE_CYC cycles apart.
- R8: req_ready is 0 from the cycle after a request is accepted until the sequence finishes. A request is taken only when req_valid and req_ready are both 1. A valid request withdrawn while ready is 0 has no effect.
- R9: cur_is_pll changes only in the cycle where done is 1, and it then shows whether the finished target is the PLL.
- R10: pll_start is a single-cycle pulse. No further step happens until pll_done returns, however long that takes.
- R11: pll_mult changes only while pll_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A switch request is present |
| req_ready | output | 1 | Block is idle and will take a request |
| req_pri | input | 2 | Target primary code |
| req_sec | input | 2 | Target secondary code |
| req_mult | input | MULT_W | Target PLL multiplier |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| cur_is_pll | output | 1 | Completed configuration runs from the PLL |
| ctrl_word | output | 8 | Select control word driven to the muxes |
| pll_start | output | 1 | One-cycle command strobe to the PLL sequencer |
| pll_en | output | 1 | Commanded PLL state (1 enable, 0 disable) |
| pll_vreg | output | 1 | Regulator request held for the PLL |
| pll_mult | output | MULT_W | Multiplier presented to the PLL |
| pll_done | input | 1 | PLL sequencer finished the commanded step |

## Verification
The done pulse that ends one sequence and the acceptance of the next request can fall in the same cycle, because req_ready returns high in the cycle done is asserted. The bench provokes this by holding req_valid high with a second request while the first is still running. It then checks three things: in the done cycle of the first request, cur_is_pll already shows the first target; the second request is taken at that same edge; and the second request ends with its own expected control word, PLL start count and regulator state. A long PLL acknowledge delay separately shows that no select write slips through while the PLL sequencer is busy.

// File: rtl/css_pkg.sv
package css_pkg;
    localparam int CTRL_W  = 8;
    localparam int STEP_W  = 3;

    localparam logic [1:0] PRI_SECMUX = 2'd0;
    localparam logic [1:0] SEC_AUX    = 2'd2;

    typedef enum logic [1:0] {
        PATH_NN = 2'd0,
        PATH_NP = 2'd1,
        PATH_PN = 2'd2,
        PATH_PP = 2'd3
    } path_e;

    typedef enum logic [2:0] {
        OP_END      = 3'd0,
        OP_SEC_AUX  = 3'd1,
        OP_SEC_TGT  = 3'd2,
        OP_PRI_PARK = 3'd3,
        OP_PRI_TGT  = 3'd4,
        OP_PLL_OFF  = 3'd5,
        OP_PLL_ON   = 3'd6,
        OP_LOAD     = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXEC   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_WAIT   = 2'd3
    } st_e;

    typedef struct packed {
        logic [1:0] pri;
        logic [1:0] sec;
    } sel_t;

    function automatic logic pri_is_pll(input logic [1:0] pri);
        return pri != PRI_SECMUX;
    endfunction

    function automatic path_e pick_path(input logic from_pll, input logic to_pll);
        case ({from_pll, to_pll})
            2'b01:   return PATH_NP;
            2'b10:   return PATH_PN;
            2'b11:   return PATH_PP;
            default: return PATH_NN;
        endcase
    endfunction

    // Step list for each path; index walks from 0 up to the OP_END entry.
    function automatic op_e step_op(input path_e p, input logic [STEP_W-1:0] idx);
        op_e r;
        r = OP_END;
        case (p)
            PATH_NN: if (idx == 3'd0) r = OP_SEC_TGT;
            PATH_NP: case (idx)
                3'd0: r = OP_LOAD;
                3'd1: r = OP_PLL_ON;
                3'd2: r = OP_PRI_TGT;
                default: r = OP_END;
            endcase
            PATH_PN: case (idx)
                3'd0: r = OP_SEC_TGT;
                3'd1: r = OP_PRI_TGT;
                3'd2: r = OP_PLL_OFF;
                default: r = OP_END;
            endcase
            default: case (idx)
                3'd0: r = OP_SEC_AUX;
                3'd1: r = OP_PRI_PARK;
                3'd2: r = OP_PLL_OFF;
                3'd3: r = OP_LOAD;
                3'd4: r = OP_PLL_ON;
                3'd5: r = OP_PRI_TGT;
                default: r = OP_END;
            endcase
        endcase
        return r;
    endfunction
endpackage

// File: rtl/css_sel_reg.sv
module css_sel_reg
    import css_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_pri,
    input  logic [1:0]        pri_val,
    input  logic              wr_sec,
    input  logic [1:0]        sec_val,
    output logic [CTRL_W-1:0] ctrl_word
);
    localparam logic [1:0] DIV_RATIO = 2'd0;

    sel_t sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q.pri <= PRI_SECMUX;
            sel_q.sec <= SEC_AUX;
        end else begin
            if (wr_pri) sel_q.pri <= pri_val;
            if (wr_sec) sel_q.sec <= sec_val;
        end
    end

    assign ctrl_word = {DIV_RATIO, 2'b00, sel_q.sec, sel_q.pri};
endmodule

// File: rtl/css_settle_timer.sv
module css_settle_timer #(
    parameter int SETTLE_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = run_q && (cnt_q == '0);
endmodule

// File: rtl/css_pll_port.sv
module css_pll_port #(
    parameter int MULT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_mult,
    input  logic [MULT_W-1:0] mult_in,
    input  logic              cmd_go,
    input  logic              cmd_en,
    input  logic              vreg_up,
    input  logic              vreg_down,
    input  logic              pll_done,
    output logic              ack,
    output logic              pll_start,
    output logic              pll_en,
    output logic              pll_vreg,
    output logic [MULT_W-1:0] pll_mult
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pll_start <= 1'b0;
            pll_en    <= 1'b0;
            pll_vreg  <= 1'b0;
            pll_mult  <= '0;
        end else begin
            pll_start <= cmd_go;
            if (cmd_go) pll_en <= cmd_en;
            if (cmd_go && cmd_en && vreg_up)     pll_vreg <= 1'b1;
            if (cmd_go && !cmd_en && vreg_down)  pll_vreg <= 1'b0;
            if (load_mult) pll_mult <= mult_in;
        end
    end

    assign ack = pll_done;
endmodule

// File: rtl/css_switch_seq.sv
module css_switch_seq
    import css_pkg::*;
#(
    parameter int MULT_W     = 8,
    parameter int SETTLE_CYC = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_pri,
    input  logic [1:0]        req_sec,
    input  logic [MULT_W-1:0] req_mult,
    output logic              done,
    output logic              cur_is_pll,
    output logic [CTRL_W-1:0] ctrl_word,
    output logic              pll_start,
    output logic              pll_en,
    output logic              pll_vreg,
    output logic [MULT_W-1:0] pll_mult,
    input  logic              pll_done
);
    st_e               state_q, state_d;
    logic [STEP_W-1:0] step_q, step_d;
    path_e             path_q;
    sel_t              tgt_q;
    logic [MULT_W-1:0] mult_q;
    logic              tgt_pll_q, cur_pll_q, done_q;
    op_e               op;

    logic       wr_pri, wr_sec, t_load, t_expired;
    logic [1:0] pri_val, sec_val;
    logic       load_mult, cmd_go, cmd_en, vreg_up, vreg_down, ack;
    logic       accept;

    assign req_ready  = (state_q == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign op         = step_op(path_q, step_q);
    assign done       = done_q;
    assign cur_is_pll = cur_pll_q;

    always_comb begin
        state_d   = state_q;
        step_d    = step_q;
        wr_pri    = 1'b0;
        wr_sec    = 1'b0;
        pri_val   = tgt_q.pri;
        sec_val   = tgt_q.sec;
        t_load    = 1'b0;
        load_mult = 1'b0;
        cmd_go    = 1'b0;
        cmd_en    = 1'b0;
        vreg_up   = 1'b0;
        vreg_down = 1'b0;
        case (state_q)
            ST_IDLE: if (accept) begin
                state_d = ST_EXEC;
                step_d  = '0;
            end
            ST_EXEC: case (op)
                OP_SEC_AUX, OP_SEC_TGT: begin
                    wr_sec  = 1'b1;
                    sec_val = (op == OP_SEC_AUX) ? SEC_AUX : tgt_q.sec;
                    t_load  = 1'b1;
                    state_d = ST_SETTLE;
                end
                OP_PRI_PARK, OP_PRI_TGT: begin
                    wr_pri  = 1'b1;
                    pri_val = (op == OP_PRI_PARK) ? PRI_SECMUX : tgt_q.pri;
                    t_load  = 1'b1;
                    state_d = ST_SETTLE;
                end
                OP_LOAD: begin
                    load_mult = 1'b1;
                    step_d    = step_q + 1'b1;
                end
                OP_PLL_OFF, OP_PLL_ON: begin
                    cmd_go    = 1'b1;
                    cmd_en    = (op == OP_PLL_ON);
                    vreg_up   = (path_q == PATH_NP);
                    vreg_down = (path_q == PATH_PN);
                    state_d   = ST_WAIT;
                end
                default: state_d = ST_IDLE;
            endcase
            ST_SETTLE: if (t_expired) begin
                state_d = ST_EXEC;
                step_d  = step_q + 1'b1;
            end
            default: if (ack) begin
                state_d = ST_EXEC;
                step_d  = step_q + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            step_q    <= '0;
            path_q    <= PATH_NN;
            tgt_q     <= '0;
            mult_q    <= '0;
            tgt_pll_q <= 1'b0;
            cur_pll_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            done_q  <= 1'b0;
            if (accept) begin
                tgt_q.pri <= req_pri;
                tgt_q.sec <= req_sec;
                mult_q    <= req_mult;
                tgt_pll_q <= pri_is_pll(req_pri);
                path_q    <= pick_path(cur_pll_q, pri_is_pll(req_pri));
            end
            if (state_q == ST_EXEC && op == OP_END) begin
                done_q    <= 1'b1;
                cur_pll_q <= tgt_pll_q;
            end
        end
    end

    css_sel_reg u_sel (
        .clk(clk), .rst(rst),
        .wr_pri(wr_pri), .pri_val(pri_val),
        .wr_sec(wr_sec), .sec_val(sec_val),
        .ctrl_word(ctrl_word)
    );

    css_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
        .clk(clk), .rst(rst), .load(t_load), .expired(t_expired)
    );

    css_pll_port #(.MULT_W(MULT_W)) u_pll (
        .clk(clk), .rst(rst),
        .load_mult(load_mult), .mult_in(mult_q),
        .cmd_go(cmd_go), .cmd_en(cmd_en),
        .vreg_up(vreg_up), .vreg_down(vreg_down),
        .pll_done(pll_done), .ack(ack),
        .pll_start(pll_start), .pll_en(pll_en),
        .pll_vreg(pll_vreg), .pll_mult(pll_mult)
    );
endmodule

// File: rtl/css_switch_seq_chk.sv
module css_switch_seq_chk #(
    parameter int MULT_W     = 8,
    parameter int SETTLE_CYC = 100
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done,
    input logic              cur_is_pll,
    input logic [7:0]        ctrl_word,
    input logic              pll_start,
    input logic              pll_en,
    input logic              pll_vreg,
    input logic [MULT_W-1:0] pll_mult
);
    localparam int GAP_W = $clog2(SETTLE_CYC + 2) + 1;

    logic [7:0]       prev_ctrl;
    logic             live_q, seen_chg_q;
    logic [GAP_W-1:0] gap_q;
    logic             chg;

    assign chg = live_q && (ctrl_word != prev_ctrl);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ctrl  <= '0;
            live_q     <= 1'b0;
            seen_chg_q <= 1'b0;
            gap_q      <= '0;
        end else begin
            prev_ctrl <= ctrl_word;
            live_q    <= 1'b1;
            if (chg) begin
                seen_chg_q <= 1'b1;
                gap_q      <= GAP_W'(1);
            end else if (gap_q < GAP_W'(SETTLE_CYC)) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    p_fields_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl_word[7:4] == 4'h0);
    p_pri_needs_pll_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_word[1:0] != 2'd0) |-> pll_en);
    p_settle_gap_r7: assert property (@(posedge clk) disable iff (rst)
        (chg && seen_chg_q) |-> (gap_q >= GAP_W'(SETTLE_CYC)));
    p_busy_ready_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    p_cur_with_done_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_is_pll) |-> done);
    p_start_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        pll_start |=> !pll_start);
    p_vreg_on_start_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(pll_vreg) |-> pll_start);
    p_mult_when_off_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(pll_mult) |-> !pll_en);
endmodule

bind css_switch_seq css_switch_seq_chk #(.MULT_W(MULT_W), .SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .done(done), .cur_is_pll(cur_is_pll), .ctrl_word(ctrl_word),
    .pll_start(pll_start), .pll_en(pll_en), .pll_vreg(pll_vreg),
    .pll_mult(pll_mult)
);

// File: tb/sim_css_switch_seq.sv
module sim_css_switch_seq;
    localparam int CLK_PERIOD = 10;
    localparam int MULT_W     = 8;
    localparam int SETTLE     = 8;

    typedef struct packed {
        logic [1:0] pri;
        logic [1:0] sec;
        logic [7:0] mult;
        logic [7:0] ctrl;
        logic [3:0] chg;
        logic [3:0] st;
        logic       pll;
        logic       vreg;
        logic [7:0] mlt;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd0, 8'hFF, 8'h00, 4'd1, 4'd0, 1'b0, 1'b0, 8'd0},
        '{2'd0, 2'd1, 8'hFF, 8'h04, 4'd1, 4'd0, 1'b0, 1'b0, 8'd0},
        '{2'd1, 2'd0, 8'd20, 8'h05, 4'd1, 4'd1, 1'b1, 1'b1, 8'd20},
        '{2'd2, 2'd0, 8'd33, 8'h0A, 4'd3, 4'd2, 1'b1, 1'b1, 8'd33},
        '{2'd1, 2'd1, 8'd40, 8'h09, 4'd2, 4'd2, 1'b1, 1'b1, 8'd40},
        '{2'd0, 2'd0, 8'hFF, 8'h00, 4'd2, 4'd1, 1'b0, 1'b0, 8'd40},
        '{2'd0, 2'd2, 8'hFF, 8'h08, 4'd1, 4'd0, 1'b0, 1'b0, 8'd40},
        '{2'd2, 2'd1, 8'd7,  8'h0A, 4'd1, 4'd1, 1'b1, 1'b1, 8'd7},
        '{2'd0, 2'd1, 8'hFF, 8'h04, 4'd2, 4'd1, 1'b0, 1'b0, 8'd7}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_pri = '0;
    logic [1:0]        req_sec = '0;
    logic [MULT_W-1:0] req_mult = '0;
    logic              done, cur_is_pll, pll_start, pll_en, pll_vreg;
    logic [7:0]        ctrl_word;
    logic [MULT_W-1:0] pll_mult;
    logic              pll_done = 1'b0;

    int errors = 0, checks = 0, cyc = 0;
    int chg_cnt = 0, st_cnt = 0, pll_lat = 3;
    int last_chg_cyc = -1000, last_done_cyc = 0;
    logic [7:0] prev_ctrl = 8'h08;
    logic       prev_cur = 1'b0;
    bit         mon_on = 1'b0;

    css_switch_seq #(.MULT_W(MULT_W), .SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_pri(req_pri), .req_sec(req_sec), .req_mult(req_mult),
        .done(done), .cur_is_pll(cur_is_pll), .ctrl_word(ctrl_word),
        .pll_start(pll_start), .pll_en(pll_en), .pll_vreg(pll_vreg),
        .pll_mult(pll_mult), .pll_done(pll_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Attached PLL sequencer model.
    initial begin
        forever begin
            @(negedge clk);
            if (pll_start) begin
                st_cnt++;
                repeat (pll_lat) @(negedge clk);
                pll_done = 1'b1;
                last_done_cyc = cyc;
                @(negedge clk);
                pll_done = 1'b0;
            end
        end
    end

    // Output monitor: settle spacing (R7), cur_is_pll only with done (R9),
    // primary PLL code only with PLL enabled (R6), upper bits zero (R2).
    always @(negedge clk) begin
        if (mon_on) begin
            if (ctrl_word != prev_ctrl) begin
                chg_cnt++;
                if (last_chg_cyc > -1000)
                    chk((cyc - last_chg_cyc) >= SETTLE, "R7 settle gap", cyc - last_chg_cyc, SETTLE);
                last_chg_cyc = cyc;
                chk(ctrl_word[7:4] == 4'h0, "R2 upper bits", ctrl_word[7:4], 0);
            end
            if (cur_is_pll != prev_cur)
                chk(done, "R9 cur_is_pll moved without done", done, 1);
            if (ctrl_word[1:0] != 2'd0 && !pll_en)
                chk(1'b0, "R6 primary on PLL while disabled", pll_en, 1);
        end
        prev_ctrl = ctrl_word;
        prev_cur  = cur_is_pll;
    end

    task automatic send(input logic [1:0] p, input logic [1:0] s, input logic [7:0] m);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_pri = p; req_sec = s; req_mult = m;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        bit  exp_pll;
        int  c0, s0;
        string tag;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ctrl_word == 8'h08, "R1 ctrl_word", ctrl_word, 8'h08);
        chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        chk({done, pll_start, pll_en, pll_vreg, cur_is_pll} == 5'b0, "R1 flags",
            {done, pll_start, pll_en, pll_vreg, cur_is_pll}, 0);
        chk(pll_mult == '0, "R1 pll_mult", pll_mult, 0);
        prev_ctrl = ctrl_word;
        mon_on = 1'b1;

        exp_pll = 1'b0;
        for (int i = 0; i < NV; i++) begin
            if (exp_pll) tag = VEC[i].pll ? "R6" : "R5";
            else         tag = VEC[i].pll ? "R4" : "R3";
            c0 = chg_cnt; s0 = st_cnt;
            send(VEC[i].pri, VEC[i].sec, VEC[i].mult);
            wait_done();
            chk(done, {tag, " done pulse"}, done, 1);
            chk(ctrl_word == VEC[i].ctrl, {tag, " R2 final ctrl_word"}, ctrl_word, VEC[i].ctrl);
            chk(chg_cnt - c0 == int'(VEC[i].chg), {tag, " select changes"}, chg_cnt - c0, VEC[i].chg);
            chk(st_cnt - s0 == int'(VEC[i].st), {tag, " R10 PLL starts"}, st_cnt - s0, VEC[i].st);
            chk(cur_is_pll == VEC[i].pll, {tag, " R9 cur_is_pll"}, cur_is_pll, VEC[i].pll);
            chk(pll_vreg == VEC[i].vreg, {tag, " regulator request"}, pll_vreg, VEC[i].vreg);
            chk(pll_en == VEC[i].pll, {tag, " pll_en"}, pll_en, VEC[i].pll);
            chk(pll_mult == VEC[i].mlt, {tag, " R11 pll_mult"}, pll_mult, VEC[i].mlt);
            exp_pll = VEC[i].pll;
        end

        // R10: long PLL acknowledge; no select write before it returns.
        pll_lat = 40;
        send(2'd1, 2'd0, 8'd9);
        wait_done();
        chk(last_chg_cyc > last_done_cyc, "R10 write after pll_done", last_chg_cyc, last_done_cyc + 1);
        chk(ctrl_word == 8'h05, "R4 ctrl after slow PLL", ctrl_word, 8'h05);
        pll_lat = 3;

        // R8: request offered and withdrawn while busy has no effect.
        send(2'd0, 2'd0, 8'hFF);
        for (int k = 0; k < 3; k++) begin
            req_valid = 1'b1; req_pri = 2'd0; req_sec = 2'd1;
            @(negedge clk);
            chk(!req_ready, "R8 ready low while busy", req_ready, 0);
        end
        req_valid = 1'b0;
        wait_done();
        chk(ctrl_word == 8'h00, "R5 ctrl after PN", ctrl_word, 8'h00);
        c0 = chg_cnt;
        repeat (30) @(negedge clk);
        chk(chg_cnt == c0 && ctrl_word == 8'h00, "R8 withdrawn request ignored", ctrl_word, 8'h00);
        chk(req_ready, "R8 ready when idle", req_ready, 1);

        // R9/R8: done and next acceptance in the same cycle.
        s0 = st_cnt;
        send(2'd1, 2'd3, 8'd12);
        req_valid = 1'b1; req_pri = 2'd0; req_sec = 2'd2; req_mult = 8'hFF;
        wait_done();
        chk(cur_is_pll == 1'b1, "R9 cur_is_pll at done", cur_is_pll, 1);
        chk(req_ready && req_valid, "R8 taken in done cycle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R8 second request accepted", req_ready, 0);
        wait_done();
        chk(ctrl_word == 8'h08, "R5 ctrl after back-to-back", ctrl_word, 8'h08);
        chk(cur_is_pll == 1'b0 && pll_vreg == 1'b0, "R5 back-to-back state", {cur_is_pll, pll_vreg}, 0);
        chk(st_cnt - s0 == 2, "R10 back-to-back starts", st_cnt - s0, 2);
        chk(pll_mult == 8'd12, "R11 mult kept on PN", pll_mult, 12);

        repeat (5) @(negedge clk);
        summary();
    end
endmodule